// File: doc/BRIEF.md
# Serial ADC Device-Side Port Model

This block is a digital stand-in for the device end of a three-wire serial converter link, for use in system tests. It runs on a fast system clock and oversamples an active-low chip select, a serial clock and a serial data input. It holds an 8-bit control byte. It picks one 12-bit word out of eight parallel sample inputs, and returns that word on a serial output that has its own output-enable, so the output can float. There is no analog front end: the samples come from registered digital inputs. The power field of the control byte only decides a wake-up flag.

A frame starts when chip select goes low. On the first eight rising serial-clock edges the port takes in a new control byte, most significant bit first. On the second rising edge it captures the sample of the channel that the control byte from the previous frame selected. It then returns four zero bits and the 12 result bits. Each output bit changes on a falling edge, so the host reads it on the following rising edge. Raising chip select floats the output. If chip select stays low after sixteen rising edges, the next sixteen edges form a new conversion.

The port is built around a three-state machine:
- IDLE: chip select is high.
- ACQUIRE: tracking, before the sample edge.
- CONVERT: the sample is held.

Its transitions are:
- IDLE→ACQUIRE when chip select is seen low.
- ACQUIRE→CONVERT on the second rising edge.
- CONVERT→ACQUIRE on the sixteenth rising edge while chip select stays low.
- Any state→IDLE when chip select is seen high.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `dout_oe` and `awake` are 0 and the control byte is zero, so the first frame returns channel 0.
- R2: While chip select is high, `dout_oe` is 0 and the output floats. While chip select is low, `dout_oe` is 1.
- R3: Every frame overwrites the control byte. The byte is shifted in MSB first on rising edges 1 to 8. The channel number is in bits [5:3] and the power field is in bits [1:0].
- R4: The channel sampled in a frame is the one held in the control byte before that frame's own write takes effect.
- R5: The sample is captured on the second rising edge of a conversion. Changes to the sample inputs after that edge do not alter the returned word.
- R6: A frame returns 16 bits: four zeros, then the 12 sample bits MSB first. Bit k (from 0) is valid at rising edge k+1 and changes only on falling edges.
- R7: If the first serial-clock edge after chip select falls is a falling edge, that edge drives the first zero and no bit is skipped.
- R8: Serial-clock edges while chip select is high are ignored and leave the control byte unchanged.
- R9: If chip select stays low past sixteen rising edges, a new conversion begins. It writes the control byte again and returns a new 16-bit frame.
- R10: Power field 00 is auto-shutdown: `awake` is 0 while idle and goes to 1 on the first falling serial-clock edge of a frame. Any other power field value keeps `awake` at 1 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial control data from the host |
| ch_data | input | CH_COUNT*SAMPLE_W (96) | Eight packed 12-bit sample words, channel 0 in the low bits |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout`; 0 means high impedance |
| awake | output | 1 | Wake-up flag decided by the power field |

## Verification
The main function is tried with several patterns. Frames that start with a rising edge and frames that start with a falling edge show whether a leading falling edge shifts the output by one bit. Back-to-back frames that select different channels separate "previous control byte" from "current control byte". A sample word is changed right after the third rising edge to pin the capture to the second edge. Clock toggles with chip select high, and a frame that keeps chip select low across two conversions, check that stray edges are ignored and that a new conversion starts on the seventeenth edge. Frames are run with the power field at 00 and at 01 to check the wake-up flag in each case.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACQUIRE = 2'd1,
        ST_CONVERT = 2'd2
    } port_state_e;

    localparam logic [1:0] PWR_AUTO_SD = 2'b00;

endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= pin;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], pin};
            end
        end
    endgenerate

    assign level = chain[STAGES-1];

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_port_pkg::*;
#(
    parameter int CTRL_W    = 8,
    parameter int FRAME_LEN = 16,
    parameter int CH_W      = 3,
    parameter int CH_LSB    = 3,
    parameter int PWR_LSB   = 0,
    parameter int CNT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low,
    input  logic              sclk_lvl,
    input  logic              din_lvl,
    output port_state_e       state,
    output logic [CNT_W-1:0]  edge_cnt,
    output logic              sclk_fall,
    output logic              sample_en,
    output logic [CH_W-1:0]   chan_sel,
    output logic              awake
);

    localparam logic [CNT_W-1:0] LAST_CTRL   = CNT_W'(CTRL_W - 1);
    localparam logic [CNT_W-1:0] LAST_EDGE   = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] SAMPLE_EDGE = CNT_W'(1);

    port_state_e         state_q, state_d;
    logic                sclk_q;
    logic                sclk_rise;
    logic                in_frame;
    logic                ctrl_commit;
    logic [CNT_W-1:0]    cnt_q;
    logic [CTRL_W-1:0]   shift_q;
    logic [CTRL_W-1:0]   ctrl_q;
    logic                awake_q;

    // Serial clock edge detection on the synchronised level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_lvl;
    end

    assign sclk_rise   = sclk_lvl & ~sclk_q;
    assign in_frame    = (state_q != ST_IDLE);
    assign ctrl_commit = in_frame && sclk_rise && (cnt_q == LAST_CTRL);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_low) state_d = ST_ACQUIRE;
            end
            ST_ACQUIRE: begin
                if (!cs_low)
                    state_d = ST_IDLE;
                else if (sclk_rise && cnt_q == SAMPLE_EDGE)
                    state_d = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (!cs_low)
                    state_d = ST_IDLE;
                else if (sclk_rise && cnt_q == LAST_EDGE)
                    state_d = ST_ACQUIRE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Rising-edge counter, cleared while idle, wraps after a full conversion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!in_frame) begin
            cnt_q <= '0;
        end else if (sclk_rise) begin
            if (cnt_q == LAST_EDGE) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
        end
    end

    // Control byte: shifted on the first CTRL_W rising edges, committed on the last
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            ctrl_q  <= '0;
        end else if (in_frame && sclk_rise && cnt_q <= LAST_CTRL) begin
            shift_q <= {shift_q[CTRL_W-2:0], din_lvl};
            if (ctrl_commit) ctrl_q <= {shift_q[CTRL_W-2:0], din_lvl};
        end
    end

    // Wake-up flag driven by the power field
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            awake_q <= 1'b0;
        else if (!in_frame)
            awake_q <= (ctrl_q[PWR_LSB +: 2] != PWR_AUTO_SD);
        else if (sclk_fall)
            awake_q <= 1'b1;
    end

    // Output process
    always_comb begin
        state     = state_q;
        edge_cnt  = cnt_q;
        sclk_fall = ~sclk_lvl & sclk_q;
        sample_en = (state_q == ST_ACQUIRE) && sclk_rise && (cnt_q == SAMPLE_EDGE) && cs_low;
        chan_sel  = ctrl_q[CH_LSB +: CH_W];
        awake     = awake_q;
    end

    AST_CNT_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (cnt_q == '0)); // R8

    AST_CTRL_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_commit |=> $stable(ctrl_q)); // R3

    AST_CONVERT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACQUIRE && state_d == ST_CONVERT) |-> sclk_rise); // R5

endmodule

// File: rtl/adc_result_shift.sv
module adc_result_shift
    import adc_port_pkg::*;
#(
    parameter int CH_COUNT   = 8,
    parameter int SAMPLE_W   = 12,
    parameter int LEAD_ZEROS = 4,
    parameter int CNT_W      = 4,
    parameter int CH_W       = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  port_state_e                  state,
    input  logic [CNT_W-1:0]             edge_cnt,
    input  logic                         sclk_fall,
    input  logic                         sample_en,
    input  logic [CH_W-1:0]              chan_sel,
    input  logic [CH_COUNT*SAMPLE_W-1:0] ch_data,
    output logic                         dout,
    output logic                         dout_oe
);

    localparam int               FRAME_LEN = LEAD_ZEROS + SAMPLE_W;
    localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] ZERO_END  = CNT_W'(LEAD_ZEROS);

    logic [SAMPLE_W-1:0]  ch_word [CH_COUNT];
    logic [SAMPLE_W-1:0]  result_q;
    logic [CNT_W-1:0]     bit_idx_q;
    logic [FRAME_LEN-1:0] frame_word;

    generate
        for (genvar g = 0; g < CH_COUNT; g++) begin : g_unpack
            assign ch_word[g] = ch_data[g*SAMPLE_W +: SAMPLE_W];
        end
    endgenerate

    // Sample capture on the conversion start edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         result_q <= '0;
        else if (sample_en) result_q <= ch_word[chan_sel];
    end

    // Output bit pointer: moves only on falling edges, to the count of rises seen
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 bit_idx_q <= '0;
        else if (state == ST_IDLE)  bit_idx_q <= '0;
        else if (sclk_fall)         bit_idx_q <= edge_cnt;
    end

    assign frame_word = {{LEAD_ZEROS{1'b0}}, result_q};

    always_comb begin
        dout_oe = (state != ST_IDLE);
        dout    = dout_oe ? frame_word[LAST_IDX - bit_idx_q] : 1'b0;
    end

    AST_LEAD_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && bit_idx_q < ZERO_END) |-> !dout); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(result_q)); // R5

    AST_IDX_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !sclk_fall) |=> $stable(bit_idx_q)); // R6

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_port_pkg::*;
#(
    parameter int CH_COUNT    = 8,
    parameter int SAMPLE_W    = 12,
    parameter int LEAD_ZEROS  = 4,
    parameter int CTRL_W      = 8,
    parameter int CH_LSB      = 3,
    parameter int PWR_LSB     = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         sclk,
    input  logic                         din,
    input  logic [CH_COUNT*SAMPLE_W-1:0] ch_data,
    output logic                         dout,
    output logic                         dout_oe,
    output logic                         awake
);

    localparam int FRAME_LEN = LEAD_ZEROS + SAMPLE_W;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int CH_W      = $clog2(CH_COUNT);

    logic              cs_lvl, sclk_lvl, din_lvl;
    port_state_e       state;
    logic [CNT_W-1:0]  edge_cnt;
    logic              sclk_fall;
    logic              sample_en;
    logic [CH_W-1:0]   chan_sel;

    adc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .pin(cs_n), .level(cs_lvl));

    adc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .pin(sclk), .level(sclk_lvl));

    adc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
        .clk(clk), .rst_n(rst_n), .pin(din), .level(din_lvl));

    adc_frame_ctrl #(
        .CTRL_W(CTRL_W), .FRAME_LEN(FRAME_LEN), .CH_W(CH_W),
        .CH_LSB(CH_LSB), .PWR_LSB(PWR_LSB), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_low(~cs_lvl), .sclk_lvl(sclk_lvl),
        .din_lvl(din_lvl), .state(state), .edge_cnt(edge_cnt),
        .sclk_fall(sclk_fall), .sample_en(sample_en), .chan_sel(chan_sel),
        .awake(awake));

    adc_result_shift #(
        .CH_COUNT(CH_COUNT), .SAMPLE_W(SAMPLE_W), .LEAD_ZEROS(LEAD_ZEROS),
        .CNT_W(CNT_W), .CH_W(CH_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .state(state), .edge_cnt(edge_cnt),
        .sclk_fall(sclk_fall), .sample_en(sample_en), .chan_sel(chan_sel),
        .ch_data(ch_data), .dout(dout), .dout_oe(dout_oe));

    AST_FLOAT_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && $past(cs_lvl)) |-> !dout_oe); // R2

endmodule

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;

    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [11:0] samp [8];
    logic [95:0] ch_data;
    logic        dout, dout_oe, awake;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [7:0]  prev_ctrl = 8'h00;

    always #10 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 8; k++) ch_data[k*12 +: 12] = samp[k];
    end

    adc_serial_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .ch_data(ch_data), .dout(dout), .dout_oe(dout_oe), .awake(awake));

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: pushes the expected word, then drives one 16-edge conversion
    task automatic frame(input logic [7:0] ctrl, input bit lead_fall, input bit keep_cs,
                         input bit mutate, input string tag);
        bit fresh;
        bit exp_wake0;
        exp_q.push_back({4'b0000, samp[prev_ctrl[5:3]]});
        tag_q.push_back(tag);
        fresh     = cs_n;
        exp_wake0 = lead_fall || (prev_ctrl[1:0] != 2'b00);
        if (fresh) begin
            sclk = lead_fall;
            wait_clk(HALF);
            cs_n = 1'b0;
            wait_clk(HALF);
            check(dout_oe == 1'b1, "R2 oe on select", 32'(dout_oe), 1);
            check(dout == 1'b0, "R7 first zero", 32'(dout), 0);
            if (lead_fall) sclk = 1'b0;
        end
        for (int i = 0; i < 16; i++) begin
            din = (i < 8) ? ctrl[7-i] : 1'b0;
            wait_clk(HALF);
            if (fresh && i == 0)
                check(awake == exp_wake0, "R10 awake before fall", 32'(awake), 32'(exp_wake0));
            if (fresh && i == 1)
                check(awake == 1'b1, "R10 awake after first fall", 32'(awake), 1);
            sclk = 1'b1;
            wait_clk(HALF);
            if (mutate && i == 2) samp[prev_ctrl[5:3]] = ~samp[prev_ctrl[5:3]];
            sclk = 1'b0;
        end
        prev_ctrl = ctrl;
        if (!keep_cs) begin
            wait_clk(HALF);
            cs_n = 1'b1;
            wait_clk(HALF + 2);
            check(dout_oe == 1'b0, "R2 float on deselect", 32'(dout_oe), 0);
            check(awake == (ctrl[1:0] != 2'b00), "R10 idle awake",
                  32'(awake), 32'(ctrl[1:0] != 2'b00));
        end
    endtask

    // Monitor: collects 16 bits per conversion at rising edges, compares with queue
    initial begin
        logic [15:0] word;
        int          n;
        logic [15:0] e;
        string       t;
        word = '0;
        n    = 0;
        forever begin
            @(posedge sclk);
            if (!cs_n) begin
                word = {word[14:0], dout};
                n++;
                if (n == 16) begin
                    n = 0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6 unexpected frame", 32'(word), 0);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(word == e, t, 32'(word), 32'(e));
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) samp[k] = 12'(12'hA53 ^ (k * 12'h1C7));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        check(dout_oe == 1'b0, "R1 reset oe", 32'(dout_oe), 0);
        check(awake == 1'b0, "R1 reset awake", 32'(awake), 0);

        frame(8'h28, 0, 0, 0, "R1 R4 channel 0 after reset");
        frame(8'h11, 0, 0, 0, "R4 R6 previous channel 5");
        frame(8'h39, 1, 0, 0, "R7 leading falling edge");
        frame(8'h19, 0, 0, 1, "R5 sample held after edge 2");

        // R8: stray clocks with chip select high, din high
        din = 1'b1;
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b1; wait_clk(HALF);
            sclk = 1'b0; wait_clk(HALF);
        end
        din = 1'b0;
        check(dout_oe == 1'b0, "R8 stray clocks keep float", 32'(dout_oe), 0);

        frame(8'h30, 0, 1, 0, "R8 stray edges ignored");
        frame(8'h08, 0, 0, 0, "R9 continuous second conversion");
        frame(8'h21, 0, 0, 0, "R3 R9 control from continuous write");
        frame(8'h00, 0, 0, 0, "R3 control overwritten");

        wait_clk(20);
        check(exp_q.size() == 0, "R6 all frames returned", 32'(exp_q.size()), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule